// File: doc/BRIEF.md
# 16-bit ALU with Persistent Status Flags

This block is the arithmetic and logic unit of a small load/store processor that has eight general registers. It takes two 16-bit operands, an 8-bit embedded immediate with a select, a 4-bit operation code, a 3-bit condition code and a flag-write enable. It returns a 16-bit result and a destination-write strobe. It also owns the processor's 8-bit status register, which holds the negative (N), zero (Z), carry (C) and overflow (V) flags.

Flags are registered and persistent. Only a flag-writing operation that is issued with the enable high changes them, and all other operations read them. One compare or logic result can therefore steer several later set-on-condition and select-on-condition operations, even when moves and loads run in between. The result word is combinational from the operands and the current flags. The status register loads on the rising clock edge that ends the operation.

Top module: `alu16_flags`

## Requirements
- R1: ADD (opcode 0) returns A+B mod 2^16. C takes the carry out of bit 15, and V is set when both operands have the same sign and the sum's sign differs from it.
- R2: ADC (opcode 1) returns A+B+C, where C is the stored carry flag. C and V are updated as for ADD, so two ADC-chained halves form a 32-bit sum.
- R3: SUB (opcode 2) returns A-B. C is set when no borrow occurs (A >= B unsigned), and V is set on signed overflow. CMP (opcode 3) updates the flags in the same way but holds dst_we low.
- R4: The status layout is bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V, and bits 7:4 read 0. N copies result bit 15, and Z is set when the result is zero. Reset clears the status to 0x00.
- R5: AND (4), OR (5) and XOR (6) update N and Z from the result and keep C and V.
- R6: The shifts move the operand by exactly one bit. SHL (7) fills the bottom bit with 0, and C takes the old bit 15. SHR (8) fills the top bit with 0, and C takes the old bit 0. ASR (9) keeps bit 15, and C takes the old bit 0. All three update N and Z and clear V.
- R7: SXW (10) returns 0xFFFF when A bit 15 is 1 and 0x0000 otherwise. It updates N and Z and keeps C and V.
- R8: SET (11) returns 1 when the condition holds on the stored flags and 0 otherwise. The condition codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 N^V.
- R9: SEL (12) returns A when the condition holds and B otherwise. SET and SEL never change the status.
- R10: When flag_we is low, the status register keeps its value whatever the operation.
- R11: When use_imm is high, the B operand is replaced by imm8 zero-extended to 16 bits.
- R12: MOV (13) returns B and leaves the flags unchanged. Opcodes 14 and 15 return 0, hold dst_we low and leave the flags unchanged. All other opcodes drive dst_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status loads on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| opcode | input | 4 | Operation select |
| cond | input | 3 | Condition code for SET and SEL |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| imm8 | input | 8 | Embedded immediate |
| use_imm | input | 1 | Replace B with the zero-extended immediate |
| flag_we | input | 1 | Allow a flag-writing operation to update the status |
| result | output | 16 | Result word |
| dst_we | output | 1 | Result should be written to the destination |
| status | output | 8 | Status register {0000, N, Z, C, V} |

## Verification
The bench goes after the carry and overflow edges: 0xFFFF+1 must wrap to zero with C set, 0x7FFF+1 must raise V, and 0x8000-1 must raise both V and not-borrow. A design that inverted the borrow sense, or took V from the wrong operand signs, would report the wrong C or V on these cases. A later ADC then shows whether the stored carry really enters the sum.

It also checks that the flags persist. An XOR must keep the C and V produced by the preceding subtract. A disabled flag write must leave the status untouched even though its add carries out. SET and SEL run with several condition codes against one status value. A design that cleared carry on logic operations, or wrote flags from SET, SEL or MOV, would break the expected status sequence.

Finally, it covers the one-bit shift-out carry on each shift type, the sign fill of SXW on both signs, the immediate replacing B, the fact that CMP does not write a result, and the unused opcodes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_CMP = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ASR = 4'd9,
        OP_SXW = 4'd10,
        OP_SET = 4'd11,
        OP_SEL = 4'd12,
        OP_MOV = 4'd13
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_CS = 3'd2,
        CC_CC = 3'd3,
        CC_MI = 3'd4,
        CC_PL = 3'd5,
        CC_VS = 3'd6,
        CC_LT = 3'd7
    } cond_e;

    // stored flag group, packed so that it maps straight onto status[3:0]
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         use_cin,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         c0;

    always_comb begin
        b_eff       = do_sub ? ~b : b;
        c0          = do_sub ? 1'b1 : (use_cin & cin);
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        ovf         = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu16_logsh.sv
module alu16_logsh #(
    parameter int W = 16
) (
    input  alu16_pkg::alu_op_e op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    output logic [W-1:0]       res,
    output logic               shout
);
    import alu16_pkg::*;

    always_comb begin
        res   = '0;
        shout = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: begin
                res   = {a[W-2:0], 1'b0};
                shout = a[W-1];
            end
            OP_SHR: begin
                res   = {1'b0, a[W-1:1]};
                shout = a[0];
            end
            OP_ASR: begin
                res   = {a[W-1], a[W-1:1]};
                shout = a[0];
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu16_cond.sv
module alu16_cond (
    input  alu16_pkg::flags_t fl,
    input  logic [2:0]        cond,
    output logic              hit
);
    import alu16_pkg::*;

    always_comb begin
        unique case (cond_e'(cond))
            CC_EQ: hit = fl.z;
            CC_NE: hit = ~fl.z;
            CC_CS: hit = fl.c;
            CC_CC: hit = ~fl.c;
            CC_MI: hit = fl.n;
            CC_PL: hit = ~fl.n;
            CC_VS: hit = fl.v;
            CC_LT: hit = fl.n ^ fl.v;
        endcase
    end
endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg #(
    parameter int SW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  alu16_pkg::flags_t nxt,
    output alu16_pkg::flags_t cur,
    output logic [SW-1:0]     status
);
    import alu16_pkg::*;

    flags_t q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= nxt;
        end
    end

    assign cur    = q;
    assign status = {{(SW-FLAG_W){1'b0}}, q};

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(nxt)));   // R4
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
    parameter int W     = 16,
    parameter int IMM_W = 8,
    parameter int SW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    opcode,
    input  logic [2:0]    cond,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [IMM_W-1:0] imm8,
    input  logic          use_imm,
    input  logic          flag_we,
    output logic [W-1:0]  result,
    output logic          dst_we,
    output logic [SW-1:0] status
);
    import alu16_pkg::*;

    alu_op_e      op;
    logic [W-1:0] b_opnd;
    logic [W-1:0] as_sum, ls_res;
    logic         as_cout, as_ovf, ls_out, hit, upd;
    flags_t       cur, nxt;

    assign op     = alu_op_e'(opcode);
    assign b_opnd = use_imm ? {{(W-IMM_W){1'b0}}, imm8} : op_b;

    alu16_addsub #(.W(W)) u_addsub (
        .a(op_a), .b(b_opnd),
        .do_sub((op == OP_SUB) || (op == OP_CMP)),
        .use_cin(op == OP_ADC), .cin(cur.c),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu16_logsh #(.W(W)) u_logsh (
        .op(op), .a(op_a), .b(b_opnd), .res(ls_res), .shout(ls_out)
    );

    alu16_cond u_cond (.fl(cur), .cond(cond), .hit(hit));

    always_comb begin
        result = '0;
        dst_we = 1'b1;
        upd    = 1'b0;
        nxt    = cur;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP: begin
                result = as_sum;
                upd    = 1'b1;
                dst_we = (op != OP_CMP);
                nxt    = '{n: as_sum[W-1], z: (as_sum == '0), c: as_cout, v: as_ovf};
            end
            OP_AND, OP_OR, OP_XOR: begin
                result = ls_res;
                upd    = 1'b1;
                nxt.n  = ls_res[W-1];
                nxt.z  = (ls_res == '0);
            end
            OP_SHL, OP_SHR, OP_ASR: begin
                result = ls_res;
                upd    = 1'b1;
                nxt    = '{n: ls_res[W-1], z: (ls_res == '0), c: ls_out, v: 1'b0};
            end
            OP_SXW: begin
                result = {W{op_a[W-1]}};
                upd    = 1'b1;
                nxt.n  = op_a[W-1];
                nxt.z  = ~op_a[W-1];
            end
            OP_SET: result = {{(W-1){1'b0}}, hit};
            OP_SEL: result = hit ? op_a : b_opnd;
            OP_MOV: result = b_opnd;
            default: begin
                result = '0;
                dst_we = 1'b0;
            end
        endcase
    end

    alu16_flagreg #(.SW(SW)) u_flags (
        .clk(clk), .rst_n(rst_n), .we(flag_we & upd),
        .nxt(nxt), .cur(cur), .status(status)
    );

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> !dst_we);   // R3
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(status));   // R10
    AST_SETSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_SET) || (op == OP_SEL) || (op == OP_MOV)) |=> $stable(status));   // R9
    AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && ((op == OP_AND) || (op == OP_OR) || (op == OP_XOR)))
        |=> (status[2] == ($past(result) == '0)));   // R5
    AST_SET_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET) |-> (result[W-1:1] == '0));   // R8
    AST_SXW_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SXW) |-> ((result == '0) || (result == '1)));   // R7
endmodule

// File: tb/alu16_flags_bench.sv
module alu16_flags_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic [2:0]  cond = '0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [7:0]  imm8 = '0;
    logic        use_imm = 1'b0, flag_we = 1'b0;
    logic [15:0] result;
    logic        dst_we;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] r;
        logic        dw;
        logic [7:0]  st;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic n_m = 0, z_m = 0, c_m = 0, v_m = 0;   // bench flag model

    always #10 clk = ~clk;   // 50 MHz

    alu16_flags u_alu16_flags (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .cond(cond),
        .op_a(op_a), .op_b(op_b), .imm8(imm8), .use_imm(use_imm),
        .flag_we(flag_we), .result(result), .dst_we(dst_we), .status(status)
    );

    function automatic bit cond_ok(input logic [2:0] cc);
        case (cc)
            3'd0: return z_m;
            3'd1: return !z_m;
            3'd2: return c_m;
            3'd3: return !c_m;
            3'd4: return n_m;
            3'd5: return !n_m;
            3'd6: return v_m;
            default: return n_m ^ v_m;
        endcase
    endfunction

    task automatic issue(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] im, input logic ui, input logic [2:0] cc,
                         input logic we, input string tag);
        logic [15:0] bb, r;
        logic [16:0] s17;
        logic        dw, nc, nv, wf;
        int          si;
        bb = ui ? {8'h00, im} : b;
        r = 16'h0; dw = 1'b1; wf = 1'b0; nc = c_m; nv = v_m;
        case (op)
            4'd0, 4'd1: begin
                s17 = {1'b0, a} + {1'b0, bb} + ((op == 4'd1 && c_m) ? 17'd1 : 17'd0);
                r = s17[15:0]; nc = s17[16];
                si = int'($signed(a)) + int'($signed(bb)) + ((op == 4'd1 && c_m) ? 1 : 0);
                nv = (si > 32767) || (si < -32768); wf = 1'b1;
            end
            4'd2, 4'd3: begin
                r = a - bb; nc = (a >= bb);
                si = int'($signed(a)) - int'($signed(bb));
                nv = (si > 32767) || (si < -32768); wf = 1'b1;
                dw = (op == 4'd2);
            end
            4'd4: begin r = a & bb; wf = 1'b1; end
            4'd5: begin r = a | bb; wf = 1'b1; end
            4'd6: begin r = a ^ bb; wf = 1'b1; end
            4'd7: begin r = a << 1; nc = a[15]; nv = 1'b0; wf = 1'b1; end
            4'd8: begin r = a >> 1; nc = a[0]; nv = 1'b0; wf = 1'b1; end
            4'd9: begin r = 16'($signed(a) >>> 1); nc = a[0]; nv = 1'b0; wf = 1'b1; end
            4'd10: begin r = a[15] ? 16'hFFFF : 16'h0000; wf = 1'b1; end
            4'd11: r = cond_ok(cc) ? 16'd1 : 16'd0;
            4'd12: r = cond_ok(cc) ? a : bb;
            4'd13: r = bb;
            default: begin r = 16'h0; dw = 1'b0; end
        endcase
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; imm8 = im; use_imm = ui; cond = cc; flag_we = we;
        if (we && wf) begin
            n_m = r[15]; z_m = (r == 16'h0); c_m = nc; v_m = nv;
        end
        sb.push_back('{r: r, dw: dw, st: {4'h0, n_m, z_m, c_m, v_m}, tag: tag});
    endtask

    // monitor: result mid low phase, status just after the edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (result !== e.r || dst_we !== e.dw) begin
                    bad++;
                    $display("FAIL %s result: got %h/%b expected %h/%b", e.tag, result, dst_we, e.r, e.dw);
                end
                @(posedge clk);
                #1;
                total++;
                if (status !== e.st) begin
                    bad++;
                    $display("FAIL %s status: got %h expected %h", e.tag, status, e.st);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (status !== 8'h00) begin
            bad++;
            $display("FAIL R4 reset status: got %h expected 00", status);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1 wrap with carry, R4 zero flag
        issue(4'd0, 16'hFFFF, 16'h0001, 8'h00, 0, 3'd0, 1, "R1 add wrap");
        issue(4'd1, 16'h0001, 16'h0002, 8'h00, 0, 3'd0, 1, "R2 adc with carry");
        issue(4'd0, 16'h7FFF, 16'h0001, 8'h00, 0, 3'd0, 1, "R1 add overflow");
        issue(4'd2, 16'h0005, 16'h0003, 8'h00, 0, 3'd0, 1, "R3 sub");
        issue(4'd3, 16'h0003, 16'h0005, 8'h00, 0, 3'd0, 1, "R3 cmp borrow");
        issue(4'd2, 16'h8000, 16'h0001, 8'h00, 0, 3'd0, 1, "R3 sub overflow");
        issue(4'd6, 16'h1234, 16'h1234, 8'h00, 0, 3'd0, 1, "R5 xor keeps C V");
        issue(4'd0, 16'hFFFF, 16'hFFFF, 8'h00, 0, 3'd0, 0, "R10 no flag write");
        issue(4'd11, 16'h0, 16'h0, 8'h00, 0, 3'd0, 1, "R8 set eq");
        issue(4'd11, 16'h0, 16'h0, 8'h00, 0, 3'd7, 1, "R8 set lt");
        issue(4'd11, 16'h0, 16'h0, 8'h00, 0, 3'd1, 1, "R8 set ne");
        issue(4'd12, 16'hAAAA, 16'h5555, 8'h00, 0, 3'd2, 1, "R9 sel cs");
        issue(4'd12, 16'hAAAA, 16'h5555, 8'h00, 0, 3'd4, 1, "R9 sel mi");
        issue(4'd13, 16'h0000, 16'hBEEF, 8'hC3, 1, 3'd0, 1, "R11 R12 mov imm");
        issue(4'd5, 16'h0100, 16'hFFFF, 8'h80, 1, 3'd0, 1, "R11 R5 or imm");
        issue(4'd7, 16'h8001, 16'h0, 8'h00, 0, 3'd0, 1, "R6 shl");
        issue(4'd8, 16'h0003, 16'h0, 8'h00, 0, 3'd0, 1, "R6 shr");
        issue(4'd10, 16'h8001, 16'h0, 8'h00, 0, 3'd0, 1, "R7 sxw negative");
        issue(4'd9, 16'h8000, 16'h0, 8'h00, 0, 3'd0, 1, "R6 asr");
        issue(4'd10, 16'h1234, 16'h0, 8'h00, 0, 3'd0, 1, "R7 sxw positive");
        issue(4'd15, 16'hFFFF, 16'hFFFF, 8'h00, 0, 3'd0, 1, "R12 unused opcode");
        issue(4'd1, 16'hFFFF, 16'h0000, 8'h00, 0, 3'd0, 1, "R2 adc no carry");
        @(negedge clk);
        flag_we = 1'b0;
        while (sb.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule